// File: doc/BRIEF.md
# Credit-Gated Rollout Stage Queues

This block holds six small queues of rollout identifiers, one for each step a rollout passes through: free, prefill, decode, reward, trajectory and done. Producers push an identifier into the queue of the stage that should handle it next. Consumers pop from a queue when they are ready to take more work. Each queue has a programmable credit ceiling that caps how many entries it may hold. Admission stops at that ceiling, which can be set well below the physical number of slots, so a slow stage pushes back on its producers early instead of filling up.

Each stage reports its current fill level and its remaining credit at all times. The decode stage also gives a batch window: the number of new decode items that may be admitted at once. Entries in the decode queue carry a remaining-step tag and a prefix tag. These tags let the decode consumer pick its next entry by plain arrival order, by fewest remaining steps, or by prefix affinity with the entry it took last. All other queues are strict first-in first-out.

Top module: `rollout_stage_queues`

## Requirements
- R1: Stages are numbered free=0, prefill=1, decode=2, reward=3, trajectory=4, done=5. Each stage's fields in the flat buses sit at offset stage×width. After reset every queue is empty, every popValid bit is 0, every credit limit equals DEPTH and every headroom equals DEPTH.
- R2: A push to a stage whose occupancy is below its limit is accepted, and occupancy rises by one at the next clock edge. An accepted push together with a pop on the same stage leaves occupancy unchanged.
- R3: A push to a stage whose occupancy is at or above its limit is refused. pushBusy for that stage is 1 in the same cycle, as a combinational function of pushValid, and the refused identifier is never delivered.
- R4: Writing cfgLimit with cfgWe for stage cfgStage sets that stage's limit, and values above DEPTH are stored as DEPTH. A limit of 0 blocks every push. A limit lowered below the present occupancy keeps the stored entries and refuses new pushes. A cfgStage value of 6 or 7 changes nothing.
- R5: occupancy reports the entry count of each stage. headroom reports limit minus occupancy, or 0 when occupancy is at or above the limit.
- R6: The free, prefill, reward, trajectory and done queues deliver identifiers in arrival order. popId shows the oldest entry whenever popValid is 1.
- R7: A pop request on an empty queue has no effect: occupancy stays 0 and popValid stays 0.
- R8: With decPolicy 0, and also with decPolicy 3, the decode queue delivers the oldest entry.
- R9: With decPolicy 1, the decode queue delivers the entry with the smallest remaining-step tag. When tags are equal, the oldest of those entries is delivered.
- R10: With decPolicy 2, the decode queue delivers the oldest entry whose prefix tag equals the prefix of the last decode entry popped. If no entry matches, it delivers the oldest entry. The last-popped prefix is 0 after reset and is updated by every decode pop, under any policy.
- R11: decodeWindow equals the decode headroom, capped at BATCH.
- R12: Removing a decode entry from the middle of the queue keeps the remaining entries in arrival order. popRemain and popPrefix always belong to the entry shown on the decode lane of popId.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Credit limit write strobe |
| cfgStage | input | 3 | Stage whose limit is written |
| cfgLimit | input | CNT_W | New credit limit |
| decPolicy | input | 2 | Decode pick rule: 0 oldest, 1 fewest remaining steps, 2 prefix affinity, 3 oldest |
| pushValid | input | 6 | Per-stage push request |
| pushId | input | 6×ID_W | Per-stage identifier to push |
| pushRemain | input | REM_W | Remaining-step tag for a decode push |
| pushPrefix | input | PFX_W | Prefix tag for a decode push |
| pushBusy | output | 6 | Per-stage refusal of a push in this cycle |
| popReq | input | 6 | Per-stage pop request |
| popValid | output | 6 | Per-stage queue not empty |
| popId | output | 6×ID_W | Per-stage identifier that a pop takes |
| popRemain | output | REM_W | Remaining-step tag of the decode entry offered |
| popPrefix | output | PFX_W | Prefix tag of the decode entry offered |
| occupancy | output | 6×CNT_W | Per-stage entry count |
| headroom | output | 6×CNT_W | Per-stage free credit |
| decodeWindow | output | CNT_W | Decode batch admission window |

## Verification
The hardest case to reach is the prefix-affinity pick. Its result depends on a hidden register: the prefix of the last decode entry popped, which may have been taken under a different policy. Its fallback path only runs when no queued entry matches. The bench reaches this in two ways. First, a directed sequence right after reset relies on the reset value of that register. Second, a long pseudo-random decode run mixes pushes, pops and all four policy codes over a narrow prefix alphabet, so matches and misses both occur often. The bench model tracks the last popped prefix from its own record of pops.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;
  localparam int NUM_STAGES   = 6;
  localparam int STG_FREE     = 0;
  localparam int STG_PREFILL  = 1;
  localparam int STG_DECODE   = 2;
  localparam int STG_REWARD   = 3;
  localparam int STG_TRAJ     = 4;
  localparam int STG_DONE     = 5;

  typedef enum logic [1:0] {
    POL_FIFO   = 2'd0,
    POL_SRF    = 2'd1,
    POL_PREFIX = 2'd2,
    POL_RSVD   = 2'd3
  } policy_e;

  // strobes from control to datapath: one accepted push and one pop per stage
  typedef struct packed {
    logic [NUM_STAGES-1:0] push;
    logic [NUM_STAGES-1:0] pop;
  } strobes_t;
endpackage

// File: rtl/rq_slotq.sv
`timescale 1ns/1ps
// Age-ordered slot queue: slot 0 is oldest; removal at any slot compacts the rest.
module rq_slotq #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic                       pop,
  input  logic [IDX_W-1:0]           removeIdx,
  input  logic [CNT_W-1:0]           occ,
  input  logic [W-1:0]               din,
  output logic [DEPTH-1:0][W-1:0]    ent
);
  logic [DEPTH-1:0][W-1:0] nxt;
  logic [CNT_W-1:0]        wrPos;

  always_comb begin
    nxt   = ent;
    wrPos = occ - CNT_W'(pop);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= removeIdx) nxt[i] = ent[i+1];
      end
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == wrPos) nxt[i] = din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ent <= '0;
    else       ent <= nxt;
  end

  // R12
  compact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && (occ > CNT_W'(removeIdx) + CNT_W'(1)) && (CNT_W'(removeIdx) < CNT_W'(DEPTH - 1)))
      |=> ent[$past(removeIdx)] == $past(ent[removeIdx + IDX_W'(1)]));
  // R6
  head_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && removeIdx == '0 && occ > CNT_W'(1)) |=> ent[0] == $past(ent[1]));
endmodule

// File: rtl/rq_pick.sv
`timescale 1ns/1ps
// Decode entry selector for the three pick rules.
module rq_pick
  import rq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int REM_W = 4,
  parameter int PFX_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CNT_W-1:0]             occ,
  input  logic [1:0]                   policy,
  input  logic [PFX_W-1:0]             lastPfx,
  input  logic [DEPTH-1:0][REM_W-1:0]  remArr,
  input  logic [DEPTH-1:0][PFX_W-1:0]  pfxArr,
  output logic [IDX_W-1:0]             sel
);
  logic [IDX_W-1:0] srfIdx, pfxIdx;
  logic [REM_W-1:0] bestRem;
  logic             found;

  always_comb begin
    bestRem = remArr[0];
    srfIdx  = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (CNT_W'(i) < occ && remArr[i] < bestRem) begin
        bestRem = remArr[i];
        srfIdx  = IDX_W'(i);
      end
    end
    found  = 1'b0;
    pfxIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && CNT_W'(i) < occ && pfxArr[i] == lastPfx) begin
        found  = 1'b1;
        pfxIdx = IDX_W'(i);
      end
    end
    case (policy)
      POL_SRF:    sel = srfIdx;
      POL_PREFIX: sel = pfxIdx;
      default:    sel = '0;
    endcase
  end

  // R10
  pfx_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (policy == POL_PREFIX && occ != '0 && pfxArr[sel] != lastPfx) |-> sel == '0);

  for (genvar j = 0; j < DEPTH; j++) begin : g_pickChk
    // R9
    srf_min_chk: assert property (@(posedge clk) disable iff (!rstN)
      (policy == POL_SRF && occ > CNT_W'(j)) |-> remArr[sel] <= remArr[j]);
    // R9
    srf_tie_chk: assert property (@(posedge clk) disable iff (!rstN)
      (policy == POL_SRF && occ > CNT_W'(j) && remArr[j] == remArr[sel]) |-> sel <= IDX_W'(j));
    // R10
    pfx_oldest_chk: assert property (@(posedge clk) disable iff (!rstN)
      (policy == POL_PREFIX && occ > CNT_W'(j) && pfxArr[j] == lastPfx) |-> sel <= IDX_W'(j));
  end
endmodule

// File: rtl/rq_ctrl.sv
`timescale 1ns/1ps
// Credit control: occupancy counters, programmable limits, admission and snapshot.
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BATCH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cfgWe,
  input  logic [2:0]                           cfgStage,
  input  logic [CNT_W-1:0]                     cfgLimit,
  input  logic [NUM_STAGES-1:0]                pushValid,
  input  logic [NUM_STAGES-1:0]                popReq,
  output strobes_t                             stb,
  output logic [NUM_STAGES-1:0]                pushBusy,
  output logic [NUM_STAGES-1:0]                popValid,
  output logic [NUM_STAGES-1:0][CNT_W-1:0]     occ,
  output logic [NUM_STAGES-1:0][CNT_W-1:0]     headroom,
  output logic [CNT_W-1:0]                     decodeWindow
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] BATCH_C = CNT_W'(BATCH);

  logic [NUM_STAGES-1:0][CNT_W-1:0] occReg, limitReg;
  logic [NUM_STAGES-1:0]            canPush;
  logic [CNT_W-1:0]                 cfgClamped;

  assign occ        = occReg;
  assign cfgClamped = (cfgLimit > DEPTH_C) ? DEPTH_C : cfgLimit;

  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      canPush[s]  = occReg[s] < limitReg[s];
      stb.push[s] = pushValid[s] && canPush[s];
      pushBusy[s] = pushValid[s] && !canPush[s];
      stb.pop[s]  = popReq[s] && (occReg[s] != '0);
      popValid[s] = occReg[s] != '0;
      headroom[s] = canPush[s] ? (limitReg[s] - occReg[s]) : '0;
    end
    decodeWindow = (headroom[STG_DECODE] > BATCH_C) ? BATCH_C : headroom[STG_DECODE];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STAGES; s++) begin
        occReg[s]   <= '0;
        limitReg[s] <= DEPTH_C;
      end
    end else begin
      for (int s = 0; s < NUM_STAGES; s++) begin
        occReg[s] <= occReg[s] + CNT_W'(stb.push[s]) - CNT_W'(stb.pop[s]);
        if (cfgWe && cfgStage == 3'(s)) limitReg[s] <= cfgClamped;
      end
    end
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_creditChk
    // R3
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pushBusy[g] && !popReq[g]) |=> occReg[g] == $past(occReg[g]));
    // R2
    accept_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pushValid[g] && !pushBusy[g] && !popReq[g]) |=> occReg[g] == $past(occReg[g]) + CNT_W'(1));
    // R4
    limit_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
      limitReg[g] <= DEPTH_C);
    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (occReg[g] == '0 && !pushValid[g]) |=> occReg[g] == '0);
  end
endmodule

// File: rtl/rq_datapath.sv
`timescale 1ns/1ps
// Queue storage for all stages; decode lane adds tags and a selector.
module rq_datapath
  import rq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 6,
  parameter int REM_W = 4,
  parameter int PFX_W = 3,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobes_t                          stb,
  input  logic [NUM_STAGES-1:0][CNT_W-1:0]  occ,
  input  logic [1:0]                        policy,
  input  logic [NUM_STAGES-1:0][ID_W-1:0]   pushId,
  input  logic [REM_W-1:0]                  pushRemain,
  input  logic [PFX_W-1:0]                  pushPrefix,
  output logic [NUM_STAGES-1:0][ID_W-1:0]   popId,
  output logic [REM_W-1:0]                  popRemain,
  output logic [PFX_W-1:0]                  popPrefix
);
  localparam int ENT_W = ID_W + REM_W + PFX_W;

  logic [IDX_W-1:0] decSel;
  logic [PFX_W-1:0] lastPfx;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s == STG_DECODE) begin : g_dec
      logic [DEPTH-1:0][ENT_W-1:0] decEnt;
      logic [DEPTH-1:0][REM_W-1:0] remArr;
      logic [DEPTH-1:0][PFX_W-1:0] pfxArr;

      rq_slotq #(.W(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_q (
        .clk(clk), .rstN(rstN), .push(stb.push[s]), .pop(stb.pop[s]),
        .removeIdx(decSel), .occ(occ[s]),
        .din({pushId[s], pushRemain, pushPrefix}), .ent(decEnt));

      always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
          remArr[i] = decEnt[i][PFX_W +: REM_W];
          pfxArr[i] = decEnt[i][PFX_W-1:0];
        end
      end

      rq_pick #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W),
                .REM_W(REM_W), .PFX_W(PFX_W)) u_pick (
        .clk(clk), .rstN(rstN), .occ(occ[s]), .policy(policy), .lastPfx(lastPfx),
        .remArr(remArr), .pfxArr(pfxArr), .sel(decSel));

      assign popId[s]  = decEnt[decSel][ENT_W-1 -: ID_W];
      assign popRemain = remArr[decSel];
      assign popPrefix = pfxArr[decSel];
    end else begin : g_plain
      logic [DEPTH-1:0][ID_W-1:0] plainEnt;
      logic [DEPTH-1:1][ID_W-1:0] tailUnused;

      rq_slotq #(.W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_q (
        .clk(clk), .rstN(rstN), .push(stb.push[s]), .pop(stb.pop[s]),
        .removeIdx('0), .occ(occ[s]), .din(pushId[s]), .ent(plainEnt));

      assign popId[s]   = plainEnt[0];
      assign tailUnused = plainEnt[DEPTH-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   lastPfx <= '0;
    else if (stb.pop[STG_DECODE]) lastPfx <= popPrefix;
  end

  // R10
  last_pfx_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop[STG_DECODE] |=> lastPfx == $past(popPrefix));
endmodule

// File: rtl/rollout_stage_queues.sv
`timescale 1ns/1ps
module rollout_stage_queues
  import rq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int ID_W  = 6,
  parameter  int REM_W = 4,
  parameter  int PFX_W = 3,
  parameter  int BATCH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWe,
  input  logic [2:0]                    cfgStage,
  input  logic [CNT_W-1:0]              cfgLimit,
  input  logic [1:0]                    decPolicy,
  input  logic [NUM_STAGES-1:0]         pushValid,
  input  logic [NUM_STAGES*ID_W-1:0]    pushId,
  input  logic [REM_W-1:0]              pushRemain,
  input  logic [PFX_W-1:0]              pushPrefix,
  output logic [NUM_STAGES-1:0]         pushBusy,
  input  logic [NUM_STAGES-1:0]         popReq,
  output logic [NUM_STAGES-1:0]         popValid,
  output logic [NUM_STAGES*ID_W-1:0]    popId,
  output logic [REM_W-1:0]              popRemain,
  output logic [PFX_W-1:0]              popPrefix,
  output logic [NUM_STAGES*CNT_W-1:0]   occupancy,
  output logic [NUM_STAGES*CNT_W-1:0]   headroom,
  output logic [CNT_W-1:0]              decodeWindow
);
  strobes_t                          stb;
  logic [NUM_STAGES-1:0][CNT_W-1:0]  occArr, headArr;
  logic [NUM_STAGES-1:0][ID_W-1:0]   pushIdArr, popIdArr;

  assign pushIdArr = pushId;
  assign popId     = popIdArr;
  assign occupancy = occArr;
  assign headroom  = headArr;

  rq_ctrl #(.DEPTH(DEPTH), .BATCH(BATCH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgStage(cfgStage), .cfgLimit(cfgLimit),
    .pushValid(pushValid), .popReq(popReq), .stb(stb), .pushBusy(pushBusy),
    .popValid(popValid), .occ(occArr), .headroom(headArr), .decodeWindow(decodeWindow));

  rq_datapath #(.DEPTH(DEPTH), .ID_W(ID_W), .REM_W(REM_W), .PFX_W(PFX_W),
                .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .occ(occArr), .policy(decPolicy),
    .pushId(pushIdArr), .pushRemain(pushRemain), .pushPrefix(pushPrefix),
    .popId(popIdArr), .popRemain(popRemain), .popPrefix(popPrefix));
endmodule

// File: tb/rollout_stage_queues_tb.sv
`timescale 1ns/1ps
module rollout_stage_queues_tb;
  localparam int NS = 6, DEPTH = 8, ID_W = 6, REM_W = 4, PFX_W = 3, BATCH = 4, CNT_W = 4;

  logic clk = 0, rstN = 0, cfgWe = 0;
  logic [2:0] cfgStage = 0;
  logic [CNT_W-1:0] cfgLimit = 0;
  logic [1:0] decPolicy = 0;
  logic [NS-1:0] pushValid = 0, popReq = 0, pushBusy, popValid;
  logic [NS*ID_W-1:0] pushId = 0, popId;
  logic [REM_W-1:0] pushRemain = 0, popRemain;
  logic [PFX_W-1:0] pushPrefix = 0, popPrefix;
  logic [NS*CNT_W-1:0] occupancy, headroom;
  logic [CNT_W-1:0] decodeWindow;

  always #4 clk = ~clk;

  rollout_stage_queues u_dut (.*);

  int nChecks = 0, nErr = 0;
  bit done = 0;
  int mCnt[NS], mLim[NS];
  int mId[NS][DEPTH];
  int mRem[DEPTH], mPfx[DEPTH];
  int mLast = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:8]) % m;
  endfunction

  function automatic int pickIdx(input int pol);
    int best = 0;
    if (mCnt[2] == 0) return 0;
    if (pol == 1) begin
      for (int i = 1; i < mCnt[2]; i++) if (mRem[i] < mRem[best]) best = i;
      return best;
    end
    if (pol == 2) begin
      for (int i = 0; i < mCnt[2]; i++) if (mPfx[i] == mLast) return i;
      return 0;
    end
    return 0;
  endfunction

  task automatic checkSnap(input string tag);
    int hr;
    for (int s = 0; s < NS; s++) begin
      hr = (mLim[s] > mCnt[s]) ? mLim[s] - mCnt[s] : 0;
      chk(occupancy[s*CNT_W +: CNT_W] == CNT_W'(mCnt[s]), tag, "occupancy",
          int'(occupancy[s*CNT_W +: CNT_W]), mCnt[s]);
      chk(headroom[s*CNT_W +: CNT_W] == CNT_W'(hr), tag, "headroom",
          int'(headroom[s*CNT_W +: CNT_W]), hr);
      chk(popValid[s] == (mCnt[s] != 0), tag, "popValid", int'(popValid[s]), int'(mCnt[s] != 0));
      if (s == 2) begin
        // R11 window is the decode headroom capped at BATCH
        chk(decodeWindow == CNT_W'(hr > BATCH ? BATCH : hr), "R11", "decodeWindow",
            int'(decodeWindow), hr > BATCH ? BATCH : hr);
      end
    end
  endtask

  task automatic setLimit(input int s, input int v);
    @(negedge clk);
    cfgWe = 1; cfgStage = 3'(s); cfgLimit = CNT_W'(v);
    @(posedge clk); #1;
    cfgWe = 0;
    if (s < NS) mLim[s] = (v > DEPTH) ? DEPTH : v;
  endtask

  task automatic doOp(input int s, input bit doPush, input int id, input int rem, input int pfx,
                      input bit doPop, input int pol, input string popTag);
    bit expBusy;
    int k;
    @(negedge clk);
    pushValid = 0; popReq = 0; pushId = 0;
    pushValid[s] = doPush; popReq[s] = doPop;
    pushId[s*ID_W +: ID_W] = ID_W'(id);
    pushRemain = REM_W'(rem); pushPrefix = PFX_W'(pfx); decPolicy = 2'(pol);
    #1;
    expBusy = doPush && (mCnt[s] >= mLim[s]);
    // R3 refusal is visible in the same cycle
    chk(pushBusy[s] == expBusy, "R3", "pushBusy", int'(pushBusy[s]), int'(expBusy));
    k = (s == 2) ? pickIdx(pol) : 0;
    if (doPop && mCnt[s] > 0) begin
      chk(popId[s*ID_W +: ID_W] == ID_W'(mId[s][k]), popTag, "popId",
          int'(popId[s*ID_W +: ID_W]), mId[s][k]);
      if (s == 2) begin
        // R12 tags follow the offered entry after compaction
        chk(popRemain == REM_W'(mRem[k]), "R12", "popRemain", int'(popRemain), mRem[k]);
        chk(popPrefix == PFX_W'(mPfx[k]), "R12", "popPrefix", int'(popPrefix), mPfx[k]);
      end
    end
    @(posedge clk); #1;
    pushValid = 0; popReq = 0;
    if (doPop && mCnt[s] > 0) begin
      if (s == 2) mLast = mPfx[k];
      for (int i = k; i < mCnt[s] - 1; i++) begin
        mId[s][i] = mId[s][i+1];
        if (s == 2) begin mRem[i] = mRem[i+1]; mPfx[i] = mPfx[i+1]; end
      end
      mCnt[s]--;
    end
    if (doPush && !expBusy) begin
      mId[s][mCnt[s]] = id & 63;
      if (s == 2) begin mRem[mCnt[s]] = rem & 15; mPfx[mCnt[s]] = pfx & 7; end
      mCnt[s]++;
    end
  endtask

  function automatic string stageTag(input int s, input int pol);
    if (s != 2) return "R6";
    if (pol == 1) return "R9";
    if (pol == 2) return "R10";
    return "R8";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin mCnt[s] = 0; mLim[s] = DEPTH; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset snapshot
    checkSnap("R1");

    // R10 directed: last prefix resets to 0, match beats age
    doOp(2, 1, 11, 5, 3, 0, 0, "R10");
    doOp(2, 1, 12, 5, 0, 0, 0, "R10");
    doOp(2, 1, 13, 5, 0, 0, 0, "R10");
    doOp(2, 0, 0, 0, 0, 1, 2, "R10");
    doOp(2, 0, 0, 0, 0, 1, 2, "R10");
    // R10 fallback: no entry has prefix 0, oldest goes
    doOp(2, 1, 14, 5, 6, 0, 0, "R10");
    doOp(2, 0, 0, 0, 0, 1, 2, "R10");
    doOp(2, 0, 0, 0, 0, 1, 2, "R10");
    checkSnap("R10");

    // R6 R7 R5 sweep over every stage and a set of limits
    foreach (mLim[s]) begin
      int lims[6] = '{0, 1, 3, 5, 8, 11};
      foreach (lims[li]) begin
        int L = lims[li];
        setLimit(s, L);
        checkSnap("R4");
        for (int k = 0; k < ((L > DEPTH) ? DEPTH : L) + 2; k++)
          doOp(s, 1, (s * 13 + k * 7 + L) & 63, (k * 5) & 15, k & 7, 0, 0, "R2");
        checkSnap("R5");
        while (mCnt[s] > 0) doOp(s, 0, 0, 0, 0, 1, 0, stageTag(s, 0));
        doOp(s, 0, 0, 0, 0, 1, 0, "R7");
        checkSnap("R7");
      end
      setLimit(s, DEPTH);
    end

    // R2 push and pop together below the limit keep the count
    setLimit(1, 3);
    doOp(1, 1, 1, 0, 0, 0, 0, "R2");
    doOp(1, 1, 2, 0, 0, 0, 0, "R2");
    doOp(1, 1, 3, 0, 0, 1, 0, "R2");
    checkSnap("R2");
    doOp(1, 1, 4, 0, 0, 0, 0, "R2");
    // R3 at the limit a push is refused even with a pop
    doOp(1, 1, 5, 0, 0, 1, 0, "R3");
    checkSnap("R3");
    while (mCnt[1] > 0) doOp(1, 0, 0, 0, 0, 1, 0, "R6");

    // R4 lowering the limit below occupancy keeps entries
    for (int k = 0; k < 5; k++) doOp(3, 1, 40 + k, 0, 0, 0, 0, "R2");
    setLimit(3, 2);
    checkSnap("R4");
    doOp(3, 1, 50, 0, 0, 0, 0, "R4");
    setLimit(6, 1);
    setLimit(7, 0);
    checkSnap("R4");
    while (mCnt[3] > 0) doOp(3, 0, 0, 0, 0, 1, 0, "R6");
    setLimit(3, DEPTH);

    // R8 R9 R10 R12 mixed decode run
    for (int n = 0; n < 600; n++) begin
      int pol = rnd(4);
      if (n == 300) setLimit(2, 6);
      if (rnd(10) < 6) doOp(2, 1, rnd(64), rnd(6), rnd(3), rnd(3) == 0, pol, stageTag(2, pol));
      else             doOp(2, 0, 0, 0, 0, 1, pol, stageTag(2, pol));
      if (n % 25 == 0) checkSnap("R11");
    end
    checkSnap("R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule